// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block keeps a four-bank DDR SDRAM refreshed. The array needs 4096 refresh commands in each 64 ms window. The block meets this by counting out the average refresh interval of 15.6 us in clock cycles. Each time the interval expires, one more refresh becomes owed. Owed refreshes are held as a debt counter. While the command path reports that it is busy, refreshes are postponed. The block catches up later by issuing the owed commands one after another.

The debt counter can hold at most eight owed refreshes. When it reaches eight, the block raises an urgent flag. It then takes the command bus even while the path is busy. Reads and writes get no grant until the debt has fallen.

Auto refresh is only legal when every bank is precharged. So each refresh sequence starts by checking the bank-idle status. If any bank is open, the block first issues a precharge-all. It waits the precharge time, then issues REFRESH. After that it keeps all other commands off the bus for the refresh row-cycle time. A refresh that falls due while eight are already owed is lost. The debt stays at eight and a sticky overflow flag is set.

Top module: `dram_refresh_sched`

## Requirements
- R1: After synchronous reset the debt is zero. `ref_req`, `ref_urgent` and `ovf_err` are low, `host_grant` is high, and the command outputs show NOP.
- R2: With `T_REFI` = N, the interval timer expires on clock edges N, 2N, 3N and so on after reset is released. Each expiry adds one to the debt. `ref_req` is high exactly when the debt is non-zero.
- R3: While `mem_busy` is high and the debt is below `MAX_DEBT`, no refresh sequence starts. `host_grant` stays high, and the bus shows NOP in the cycle after any cycle with `host_grant` high.
- R4: `ref_urgent` is high exactly when the debt equals `MAX_DEBT` (8 by default). While it is high, `host_grant` is low and a sequence starts whatever the state of `mem_busy`.
- R5: When the timer expires with the debt at `MAX_DEBT` and no REFRESH in that cycle, the debt stays at `MAX_DEBT` and `ovf_err` goes high. `ovf_err` stays high until reset.
- R6: When a sequence starts while any `banks_idle` bit is low, the next cycle carries precharge-all. Precharge-all is cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1. REFRESH follows exactly `T_RP` cycles after it, with NOP in between.
- R7: When a sequence starts with every `banks_idle` bit high, the next cycle carries REFRESH with no precharge-all. REFRESH is only ever issued while all banks are idle.
- R8: In each cycle the command outputs {cs_n, ras_n, cas_n, we_n, a10} show exactly one of three encodings. NOP is 1,1,1,1,0. Precharge-all is as in R6. REFRESH is 0,0,0,1,0.
- R9: For `T_RFC`-1 cycles after a REFRESH cycle, the bus shows NOP and `host_grant` is low. A REFRESH removes one from the debt at the following edge.
- R10: At the end of the `T_RFC` window (cycle REFRESH+`T_RFC`), a new sequence starts if debt remains and either `mem_busy` is low or the block is urgent. Owed refreshes are therefore issued back to back, `T_RFC`+1 cycles apart when no precharge is needed.
- R11: `host_grant` is low in the cycle a sequence starts and in every cycle until the `T_RFC` window ends. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_busy | input | 1 | Command path has traffic pending; refresh may be postponed |
| banks_idle | input | NBANK | Per-bank precharged status, 1 = idle |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Debt is at its limit; refresh takes priority |
| host_grant | output | 1 | Command path may issue its own command this cycle |
| cmd_cs_n | output | 1 | Command chip select, active low |
| cmd_ras_n | output | 1 | Command row strobe, active low |
| cmd_cas_n | output | 1 | Command column strobe, active low |
| cmd_we_n | output | 1 | Command write enable, active low |
| cmd_a10 | output | 1 | Address bit 10; high selects all banks for precharge |
| ovf_err | output | 1 | Sticky flag: a refresh was lost at the debt limit |

## Verification
The debt-driven outputs `ref_req`, `ref_urgent` and `ovf_err` change one cycle after the timer's last count or after a REFRESH cycle. The bench applies both events to its debt model at the following edge, before comparing. A sequence begins in the cycle where `host_grant` falls. The bench then expects the precharge-all or REFRESH one cycle later, REFRESH exactly `T_RP` cycles after a precharge-all, and a possible grant or new start exactly `T_RFC` cycles after the REFRESH. Inputs change just after each rising edge and outputs are read at the falling edge. A per-cycle phase tracker in the bench knows which of these deadlines applies in every cycle. A second instance, whose refresh row time exceeds its interval, drives the debt into saturation and overflow.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRE,
        SQ_TRP,
        SQ_REF,
        SQ_TRFC
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_NOP  = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam dram_cmd_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
    localparam dram_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
    parameter int T_REFI = 2080
) (
    input  logic clk,
    input  logic rst,
    output logic due
);
    import dram_ref_pkg::*;

    localparam int TW = cnt_width(T_REFI);
    localparam logic [TW-1:0] LAST = TW'(T_REFI - 1);

    logic [TW-1:0] cnt_q;

    assign due = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (due) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ref_debt.sv
module ref_debt #(
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic due,
    input  logic ref_done,
    output logic pending,
    output logic urgent,
    output logic ovf_err
);
    import dram_ref_pkg::*;

    localparam int DW = cnt_width(MAX_DEBT + 1);
    localparam logic [DW-1:0] LIMIT = DW'(MAX_DEBT);

    logic [DW-1:0] debt_q;
    logic          ovf_q;

    assign pending = (debt_q != '0);
    assign urgent  = (debt_q == LIMIT);
    assign ovf_err = ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            debt_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            unique case ({due, ref_done})
                2'b10: begin
                    if (debt_q == LIMIT) begin
                        ovf_q <= 1'b1;
                    end else begin
                        debt_q <= debt_q + 1'b1;
                    end
                end
                2'b01: begin
                    if (debt_q != '0) begin
                        debt_q <= debt_q - 1'b1;
                    end
                end
                default: begin
                    debt_q <= debt_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/ref_seq.sv
module ref_seq #(
    parameter int NBANK = 4,
    parameter int T_RP  = 3,
    parameter int T_RFC = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pending,
    input  logic                     urgent,
    input  logic                     mem_busy,
    input  logic [NBANK-1:0]         banks_idle,
    output dram_ref_pkg::dram_cmd_t  cmd,
    output logic                     ref_done,
    output logic                     host_grant
);
    import dram_ref_pkg::*;

    localparam int WW = cnt_width(max2(T_RP, T_RFC));
    localparam logic [WW-1:0] RP_LAST  = WW'(T_RP - 2);
    localparam logic [WW-1:0] RFC_LAST = WW'(T_RFC - 2);

    seq_state_e    state_q, state_d;
    logic [WW-1:0] wait_q;
    logic          start;
    logic          all_idle;
    logic          wait_done;

    assign all_idle = &banks_idle;
    assign start    = pending && (!mem_busy || urgent);

    always_comb begin
        wait_done = 1'b0;
        if (state_q == SQ_TRP) begin
            wait_done = (wait_q == RP_LAST);
        end else if (state_q == SQ_TRFC) begin
            wait_done = (wait_q == RFC_LAST);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    state_d = all_idle ? SQ_REF : SQ_PRE;
                end
            end
            SQ_PRE:  state_d = SQ_TRP;
            SQ_TRP:  if (wait_done) state_d = SQ_REF;
            SQ_REF:  state_d = SQ_TRFC;
            SQ_TRFC: if (wait_done) state_d = SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            if ((state_q == SQ_TRP || state_q == SQ_TRFC) && !wait_done) begin
                wait_q <= wait_q + 1'b1;
            end else begin
                wait_q <= '0;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            SQ_PRE:  cmd = CMD_PREA;
            SQ_REF:  cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
    end

    assign ref_done   = (state_q == SQ_REF);
    assign host_grant = (state_q == SQ_IDLE) && !start;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int T_REFI   = 2080,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 10,
    parameter int MAX_DEBT = 8,
    parameter int NBANK    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mem_busy,
    input  logic [NBANK-1:0] banks_idle,
    output logic             ref_req,
    output logic             ref_urgent,
    output logic             host_grant,
    output logic             cmd_cs_n,
    output logic             cmd_ras_n,
    output logic             cmd_cas_n,
    output logic             cmd_we_n,
    output logic             cmd_a10,
    output logic             ovf_err
);
    import dram_ref_pkg::*;

    logic      tick_due;
    logic      ref_done;
    logic      pending;
    logic      urgent;
    dram_cmd_t cmd_bus;

    refi_timer #(.T_REFI(T_REFI)) u_timer (
        .clk (clk),
        .rst (rst),
        .due (tick_due)
    );

    ref_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk      (clk),
        .rst      (rst),
        .due      (tick_due),
        .ref_done (ref_done),
        .pending  (pending),
        .urgent   (urgent),
        .ovf_err  (ovf_err)
    );

    ref_seq #(.NBANK(NBANK), .T_RP(T_RP), .T_RFC(T_RFC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .pending    (pending),
        .urgent     (urgent),
        .mem_busy   (mem_busy),
        .banks_idle (banks_idle),
        .cmd        (cmd_bus),
        .ref_done   (ref_done),
        .host_grant (host_grant)
    );

    assign ref_req    = pending;
    assign ref_urgent = urgent;
    assign cmd_cs_n   = cmd_bus.cs_n;
    assign cmd_ras_n  = cmd_bus.ras_n;
    assign cmd_cas_n  = cmd_bus.cas_n;
    assign cmd_we_n   = cmd_bus.we_n;
    assign cmd_a10    = cmd_bus.a10;
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             due,
    input logic             ref_done,
    input logic             ref_req,
    input logic             ref_urgent,
    input logic             host_grant,
    input logic [4:0]       cmd,
    input logic [NBANK-1:0] banks_idle,
    input logic             ovf_err
);
    import dram_ref_pkg::*;

    logic is_nop, is_prea, is_ref;
    assign is_nop  = (cmd == CMD_NOP);
    assign is_prea = (cmd == CMD_PREA);
    assign is_ref  = (cmd == CMD_REF);

    // R8
    legal_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        is_nop || is_prea || is_ref);

    // R7
    ref_all_idle_chk: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> (&banks_idle));

    // R9
    rfc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        is_ref |=> (is_nop && !host_grant));

    // R6
    prea_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        is_prea |=> (is_nop && !host_grant));

    // R3
    grant_then_nop_chk: assert property (@(posedge clk) disable iff (rst)
        host_grant |=> is_nop);

    // R4
    urgent_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> !host_grant);

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);

    // R2
    due_raises_req_chk: assert property (@(posedge clk) disable iff (rst)
        (due && !ref_done) |=> ref_req);

    // R10
    req_falls_after_ref_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_req) |-> $past(ref_done));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.NBANK(NBANK)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .due        (tick_due),
    .ref_done   (ref_done),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .host_grant (host_grant),
    .cmd        (cmd_bus),
    .banks_idle (banks_idle),
    .ovf_err    (ovf_err)
);

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/100ps
module dram_refresh_sched_tb_top;

    localparam int NB   = 4;
    localparam int MAXD = 8;
    localparam int T1   = 40;
    localparam int RP1  = 3;
    localparam int RFC1 = 10;
    localparam int T2   = 10;
    localparam int RP2  = 2;
    localparam int RFC2 = 12;

    localparam logic [4:0] NOP  = 5'b11110;
    localparam logic [4:0] PREA = 5'b00101;
    localparam logic [4:0] REFC = 5'b00010;

    typedef enum int {P_IDLE, P_DEC, P_PW, P_RFC} ph_e;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          busy = 1'b0;
    logic [NB-1:0] bidle = '1;
    logic req, urg, grant, cs, ras, cas, we, a10, ovf;
    logic req2, urg2, grant2, cs2, ras2, cas2, we2, a102, ovf2;

    dram_refresh_sched #(.T_REFI(T1), .T_RP(RP1), .T_RFC(RFC1), .MAX_DEBT(MAXD), .NBANK(NB)) dut_i (
        .clk(clk), .rst(rst), .mem_busy(busy), .banks_idle(bidle),
        .ref_req(req), .ref_urgent(urg), .host_grant(grant),
        .cmd_cs_n(cs), .cmd_ras_n(ras), .cmd_cas_n(cas), .cmd_we_n(we), .cmd_a10(a10),
        .ovf_err(ovf)
    );

    dram_refresh_sched #(.T_REFI(T2), .T_RP(RP2), .T_RFC(RFC2), .MAX_DEBT(MAXD), .NBANK(NB)) dut_ovf_i (
        .clk(clk), .rst(rst), .mem_busy(1'b0), .banks_idle({NB{1'b1}}),
        .ref_req(req2), .ref_urgent(urg2), .host_grant(grant2),
        .cmd_cs_n(cs2), .cmd_ras_n(ras2), .cmd_cas_n(cas2), .cmd_we_n(we2), .cmd_a10(a102),
        .ovf_err(ovf2)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int cyc;
    int ed, ed2;
    bit eovf, eovf2;
    bit pref, pref2;
    ph_e ph;
    int  mark;
    bit  needpre;
    logic [NB-1:0] bopen;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    function automatic int upd_debt(input int d, input bit dec, input bit due_now,
                                    inout bit ov);
        int n;
        n = dec ? d - 1 : d;
        if (due_now) begin
            if (n == MAXD) ov = 1'b1;
            else n = n + 1;
        end
        return n;
    endfunction

    function automatic bit legal(input logic [4:0] v);
        return (v == NOP) || (v == PREA) || (v == REFC);
    endfunction

    task automatic idle_check(input logic [4:0] cmdv, input bit after_rfc);
        bit st;
        string tg;
        st = (ed != 0) && (!busy || ed == MAXD);
        if (after_rfc) tg = "R10";
        else if (ed == MAXD) tg = "R4";
        else if (busy) tg = "R3";
        else tg = "R11";
        chk(cmdv == NOP, tg, "idle command", int'(cmdv), int'(NOP));
        chk(grant == !st, tg, "grant in idle", int'(grant), int'(!st));
        if (st) begin
            ph = P_DEC;
            needpre = (bidle != '1);
        end
    endtask

    task automatic check_cycle();
        logic [4:0] cmdv, cmdv2;
        bit after_rfc;
        cmdv  = {cs, ras, cas, we, a10};
        cmdv2 = {cs2, ras2, cas2, we2, a102};
        if (cyc > 0) begin
            ed  = upd_debt(ed,  pref,  (cyc % T1) == 0, eovf);
            ed2 = upd_debt(ed2, pref2, (cyc % T2) == 0, eovf2);
        end
        pref  = (cmdv == REFC);
        pref2 = (cmdv2 == REFC);

        chk(req == (ed != 0), "R2", "ref_req", int'(req), int'(ed != 0));
        chk(urg == (ed == MAXD), "R4", "ref_urgent", int'(urg), int'(ed == MAXD));
        chk(ovf == eovf, "R5", "ovf_err", int'(ovf), int'(eovf));
        chk(legal(cmdv), "R8", "command encoding", int'(cmdv), int'(NOP));
        chk(req2 == (ed2 != 0), "R2", "ref_req second instance", int'(req2), int'(ed2 != 0));
        chk(urg2 == (ed2 == MAXD), "R5", "saturated urgent second instance", int'(urg2), int'(ed2 == MAXD));
        chk(ovf2 == eovf2, "R5", "ovf_err second instance", int'(ovf2), int'(eovf2));
        chk(legal(cmdv2), "R8", "command encoding second instance", int'(cmdv2), int'(NOP));

        after_rfc = 1'b0;
        if (ph == P_RFC && (cyc - mark) >= RFC1) begin
            ph = P_IDLE;
            after_rfc = 1'b1;
        end
        case (ph)
            P_IDLE: idle_check(cmdv, after_rfc);
            P_DEC: begin
                chk(grant == 1'b0, "R11", "grant at first command", int'(grant), 0);
                if (needpre) begin
                    chk(cmdv == PREA, "R6", "precharge-all first", int'(cmdv), int'(PREA));
                    ph = P_PW;
                end else begin
                    chk(cmdv == REFC, "R7", "direct refresh", int'(cmdv), int'(REFC));
                    ph = P_RFC;
                end
                mark = cyc;
            end
            P_PW: begin
                chk(grant == 1'b0, "R6", "grant during precharge wait", int'(grant), 0);
                if ((cyc - mark) < RP1) begin
                    chk(cmdv == NOP, "R6", "nop during precharge wait", int'(cmdv), int'(NOP));
                end else begin
                    chk(cmdv == REFC, "R6", "refresh after precharge time", int'(cmdv), int'(REFC));
                    chk(bidle == '1, "R7", "banks idle at refresh", int'(bidle), (1 << NB) - 1);
                    ph = P_RFC;
                    mark = cyc;
                end
            end
            default: begin
                chk(cmdv == NOP, "R9", "nop during refresh recovery", int'(cmdv), int'(NOP));
                chk(grant == 1'b0, "R9", "grant during refresh recovery", int'(grant), 0);
            end
        endcase
    endtask

    task automatic host_model();
        logic [4:0] cmdv;
        int r;
        cmdv = {cs, ras, cas, we, a10};
        if (cmdv == PREA) begin
            bopen = '0;
        end else if (grant) begin
            r = int'($urandom % 100);
            if (r < 30) bopen[$urandom % NB] = 1'b1;
            else if (r < 40) bopen[$urandom % NB] = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        busy  = 1'b0;
        bopen = '0;
        bidle = '1;
        repeat (3) @(posedge clk);
        #1;
        rst  = 1'b0;
        cyc  = 0;
        ed   = 0;
        ed2  = 0;
        eovf = 1'b0;
        eovf2 = 1'b0;
        pref = 1'b0;
        pref2 = 1'b0;
        ph   = P_IDLE;
        mark = 0;
        needpre = 1'b0;
        @(negedge clk);
        chk(req == 1'b0, "R1", "reset ref_req", int'(req), 0);
        chk(urg == 1'b0, "R1", "reset ref_urgent", int'(urg), 0);
        chk(ovf == 1'b0, "R1", "reset ovf_err", int'(ovf), 0);
        chk(grant == 1'b1, "R1", "reset host_grant", int'(grant), 1);
        chk({cs, ras, cas, we, a10} == NOP, "R1", "reset command", int'({cs, ras, cas, we, a10}), int'(NOP));
        check_cycle();
        host_model();
        cyc = 1;
    endtask

    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            case (mode)
                0: busy = (($urandom % 100) < 25);
                1: busy = 1'b1;
                2: busy = 1'b0;
                default: busy = (($urandom % 100) < 50);
            endcase
            bidle = ~bopen;
            @(negedge clk);
            check_cycle();
            host_model();
            cyc++;
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();
        run(600, 0);
        run(450, 1);
        run(300, 2);
        do_reset();
        run(2000, 3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule